// File: doc/BRIEF.md
# Watermark-Gated Transmit Frame FIFO

This block is a byte-wide transmit queue placed between a host write port and a MAC transmit engine. The host pushes bytes one per cycle, each with a flag that marks the last byte of a frame. The transmit side does not see data as soon as the queue is non-empty. A start request is raised only when enough of the current frame is queued. "Enough" means one of three things: the number of queued bytes has reached a threshold picked by a 2-bit code, a complete frame (its end-of-frame byte) is already stored, or the storage is full. After the request is up, the transmitter drains bytes through a ready/valid handshake. The request stays up until the end-of-frame byte has left the queue.

The threshold code is held in a small register written from the host side. It is consulted only while no frame has been released, so a change affects the next frame that is not yet requested. A write that arrives while the queue is full is dropped and sets a sticky overflow flag. A released frame that runs dry before its end-of-frame byte arrives produces a one-cycle underrun pulse.

Top module: `tx_gate_fifo`

## Requirements
- R1: A synchronous active-high reset empties the queue (`fill_level` 0, `full` 0, `tx_valid` 0). It lowers `tx_start`, clears `ovf_flag` and `underrun`, and sets the threshold code to 00.
- R2: The threshold code decodes as 00 or 01 to STEP bytes (64 by default), 10 to 2×STEP, and 11 to 3×STEP. With no end-of-frame byte stored and the queue not full, `tx_start` stays low while `fill_level` is below the decoded threshold, and rises once it reaches it.
- R3: A write with `wr_valid` high while `full` is high is dropped, and `fill_level` never exceeds DEPTH. The same write sets `ovf_flag`, which stays set until a cycle with `ovf_clr` high and no new dropped write. A dropped write in the clearing cycle keeps the flag set.
- R4: With at least one stored byte carrying the end-of-frame bit, `tx_start` rises even below the threshold.
- R5: With the queue full, `tx_start` rises even when the decoded threshold exceeds DEPTH.
- R6: Once high, `tx_start` stays high until a cycle in which the transmitter accepts the byte whose end-of-frame bit is set. It is low in the cycle after that. The next frame is then judged again from the bytes already queued.
- R7: `tx_valid` is high exactly when `tx_start` is high and the queue is not empty. `tx_data`/`tx_eof` present the bytes in write order with their end-of-frame bits, and a byte leaves when `tx_valid` and `tx_ready` are both high.
- R8: `fill_level` rises by one for each accepted write and falls by one for each accepted read, and is unchanged when both occur in the same cycle.
- R9: Writing a new threshold code while `tx_start` is high does not lower `tx_start` and does not affect the frame already released.
- R10: When an accepted read takes the last queued byte, that byte lacks the end-of-frame bit, and no write is accepted in the same cycle, `underrun` is high for exactly one cycle after that edge.
- R11: `tx_start` is registered: it rises on the clock edge after the edge that made the start condition true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Byte written by the host |
| wr_eof | input | 1 | Marks the written byte as the last of its frame |
| cfg_we | input | 1 | Loads the threshold code |
| cfg_wm | input | 2 | New threshold code |
| ovf_clr | input | 1 | Clears the overflow flag (write-one-to-clear) |
| tx_ready | input | 1 | Transmitter accepts the presented byte |
| tx_start | output | 1 | Frame start request to the transmitter |
| tx_valid | output | 1 | A byte of the released frame is presented |
| tx_data | output | DATA_W | Presented byte |
| tx_eof | output | 1 | Presented byte ends the frame |
| fill_level | output | $clog2(DEPTH+1) | Bytes currently stored |
| full | output | 1 | Queue holds DEPTH bytes |
| ovf_flag | output | 1 | Sticky: a write was dropped while full |
| underrun | output | 1 | One-cycle pulse: released frame ran dry before its end |

## Verification
The bench uses a non-power-of-two depth of 160. This makes the 11 code (192 bytes) unreachable, so the only way to start is a full queue. A design that ignored fullness would stall forever, and one that wrapped pointers as if the depth were a power of two would replay stale bytes. Each threshold code is probed one byte below and at its level, so a wrong decode or an off-by-one comparison shows up as an early or late request. A frame is drained dry before its end byte arrives: a design that dropped the request on empty would lose the tail, and a missing or stretched underrun pulse is counted. Back-to-back stored frames check that the request drops for a cycle between frames. Writes into a full queue check that dropped bytes never appear on the transmit side.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

   typedef enum logic [1:0] {
      WM_ONE_A = 2'b00,
      WM_ONE_B = 2'b01,
      WM_TWO   = 2'b10,
      WM_THREE = 2'b11
   } wm_code_e;

   // Byte threshold selected by a watermark code, in multiples of step.
   function automatic int unsigned wm_threshold(input logic [1:0] code,
                                                input int unsigned step);
      case (code)
         WM_TWO:   return 2 * step;
         WM_THREE: return 3 * step;
         default:  return step;
      endcase
   endfunction

endpackage

// File: rtl/tgf_store.sv
module tgf_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 256,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W:0]   wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W:0]   rdata
);

   logic [DATA_W:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/tgf_occ.sv
module tgf_occ #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           push,
   input  logic           push_eof,
   input  logic           pop,
   input  logic           pop_eof,
   output logic [AW-1:0]  wptr,
   output logic [AW-1:0]  rptr,
   output logic [CW-1:0]  level,
   output logic           full,
   output logic           empty,
   output logic           eof_any
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   logic [AW-1:0] wptr_inc;
   logic [AW-1:0] rptr_inc;
   logic [CW-1:0] eof_cnt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wptr_inc = wptr + 1'b1;
         assign rptr_inc = rptr + 1'b1;
      end else begin : g_wrap
         assign wptr_inc = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
         assign rptr_inc = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         eof_cnt <= '0;
      end else begin
         if (push) begin
            wptr <= wptr_inc;
         end
         if (pop) begin
            rptr <= rptr_inc;
         end
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         case ({push & push_eof, pop & pop_eof})
            2'b10:   eof_cnt <= eof_cnt + 1'b1;
            2'b01:   eof_cnt <= eof_cnt - 1'b1;
            default: eof_cnt <= eof_cnt;
         endcase
      end
   end

   assign full    = (level == FULL_LVL);
   assign empty   = (level == '0);
   assign eof_any = (eof_cnt != '0);

endmodule

// File: rtl/tgf_ctrl.sv
module tgf_ctrl #(
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned WM_STEP = 64,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cfg_we,
   input  logic [1:0]     cfg_wm,
   input  logic           ovf_clr,
   input  logic           wr_valid,
   input  logic           push,
   input  logic           pop,
   input  logic           pop_eof,
   input  logic [CW-1:0]  level,
   input  logic           full,
   input  logic           eof_any,
   output logic           tx_start,
   output logic           underrun,
   output logic           ovf_flag
);

   import tgf_pkg::*;

   logic [1:0]  wm_q;
   int unsigned thr;
   logic        go;
   logic        frame_done;
   logic        runs_dry;

   assign thr        = wm_threshold(wm_q, WM_STEP);
   assign go         = (32'(level) >= thr) || eof_any || full;
   assign frame_done = pop && pop_eof;
   assign runs_dry   = pop && !pop_eof && (level == CW'(1)) && !push;

   always_ff @(posedge clk) begin
      if (rst) begin
         wm_q     <= WM_ONE_A;
         tx_start <= 1'b0;
         underrun <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (cfg_we) begin
            wm_q <= cfg_wm;
         end
         tx_start <= tx_start ? !frame_done : go;
         underrun <= runs_dry;
         if (wr_valid && full) begin
            ovf_flag <= 1'b1;
         end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tx_gate_fifo.sv
module tx_gate_fifo #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned WM_STEP = 64,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eof,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_wm,
   input  logic              ovf_clr,
   input  logic              tx_ready,
   output logic              tx_start,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_eof,
   output logic [CW-1:0]     fill_level,
   output logic              full,
   output logic              ovf_flag,
   output logic              underrun
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tx_gate_fifo: DEPTH must be at least 2");
      end
      if (WM_STEP < 1 || WM_STEP > DEPTH) begin : g_bad_step
         $error("tx_gate_fifo: WM_STEP must lie in 1..DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("tx_gate_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [AW-1:0]   wptr;
   logic [AW-1:0]   rptr;
   logic [DATA_W:0] head;
   logic            empty;
   logic            eof_any;
   logic            push;
   logic            pop;

   assign push     = wr_valid && !full;
   assign tx_valid = tx_start && !empty;
   assign pop      = tx_valid && tx_ready;
   assign tx_data  = head[DATA_W-1:0];
   assign tx_eof   = head[DATA_W];

   tgf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (push),
      .waddr (wptr),
      .wdata ({wr_eof, wr_data}),
      .raddr (rptr),
      .rdata (head)
   );

   tgf_occ #(.DEPTH(DEPTH)) u_occ (
      .clk      (clk),
      .rst      (rst),
      .push     (push),
      .push_eof (wr_eof),
      .pop      (pop),
      .pop_eof  (tx_eof),
      .wptr     (wptr),
      .rptr     (rptr),
      .level    (fill_level),
      .full     (full),
      .empty    (empty),
      .eof_any  (eof_any)
   );

   tgf_ctrl #(.DEPTH(DEPTH), .WM_STEP(WM_STEP)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we),
      .cfg_wm   (cfg_wm),
      .ovf_clr  (ovf_clr),
      .wr_valid (wr_valid),
      .push     (push),
      .pop      (pop),
      .pop_eof  (tx_eof),
      .level    (fill_level),
      .full     (full),
      .eof_any  (eof_any),
      .tx_start (tx_start),
      .underrun (underrun),
      .ovf_flag (ovf_flag)
   );

endmodule

// File: rtl/tgf_checker.sv
module tgf_checker #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_valid,
   input logic          tx_ready,
   input logic          ovf_clr,
   input logic          tx_start,
   input logic          tx_valid,
   input logic          tx_eof,
   input logic [CW-1:0] fill_level,
   input logic          full,
   input logic          ovf_flag,
   input logic          underrun
);

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (fill_level == '0) && !tx_start && !ovf_flag && !underrun);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      fill_level <= CW'(DEPTH));

   p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && full) |=> ovf_flag);

   p_full_start_r5: assert property (@(posedge clk) disable iff (rst)
      (full && !tx_start) |=> tx_start);

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (tx_start && !(tx_valid && tx_ready && tx_eof)) |=> tx_start);

   p_drop_r6: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_ready && tx_eof) |=> !tx_start);

   p_valid_r7: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> (tx_start && fill_level != '0));

   p_level_up_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !full && !(tx_valid && tx_ready))
         |=> fill_level == $past(fill_level) + 1'b1);

   p_level_down_r8: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && tx_valid && tx_ready)
         |=> fill_level == $past(fill_level) - 1'b1);

   p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      underrun |=> !underrun);

endmodule

bind tx_gate_fifo tgf_checker #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_valid   (wr_valid),
   .tx_ready   (tx_ready),
   .ovf_clr    (ovf_clr),
   .tx_start   (tx_start),
   .tx_valid   (tx_valid),
   .tx_eof     (tx_eof),
   .fill_level (fill_level),
   .full       (full),
   .ovf_flag   (ovf_flag),
   .underrun   (underrun)
);

// File: tb/tx_gate_fifo_tb.sv
module tx_gate_fifo_tb;

   localparam int DW    = 8;
   localparam int DEPTH = 160;
   localparam int STEP  = 64;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_eof = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_wm = '0;
   logic          ovf_clr = 1'b0;
   logic          tx_ready = 1'b0;
   logic          tx_start, tx_valid, tx_eof, full, ovf_flag, underrun;
   logic [DW-1:0] tx_data;
   logic [CW-1:0] fill_level;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int upulses = 0;
   logic [7:0] seq = 8'd1;

   tx_gate_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .WM_STEP(STEP)) u_dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_eof(wr_eof), .cfg_we(cfg_we), .cfg_wm(cfg_wm), .ovf_clr(ovf_clr),
      .tx_ready(tx_ready), .tx_start(tx_start), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_eof(tx_eof), .fill_level(fill_level),
      .full(full), .ovf_flag(ovf_flag), .underrun(underrun)
   );

   always #5 clk = ~clk;

   // Reference model state
   logic [DW:0] q[$];
   bit  m_start = 0, m_ovf = 0, m_und = 0;
   int  m_wm = 0;

   function automatic int thr_of(int code);
      if (code == 2) return 2 * STEP;
      if (code == 3) return 3 * STEP;
      return STEP;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         q.delete();
         m_start = 0; m_ovf = 0; m_und = 0; m_wm = 0;
      end else begin
         bit is_full, pop, hd_eof, wacc, go, n_start, n_und, n_ovf;
         int eofs;
         eofs = 0;
         foreach (q[i]) if (q[i][DW]) eofs++;
         is_full = (q.size() == DEPTH);
         pop     = m_start && (q.size() > 0) && tx_ready;
         hd_eof  = (q.size() > 0) ? q[0][DW] : 1'b0;
         wacc    = wr_valid && !is_full;
         go      = (q.size() >= thr_of(m_wm)) || (eofs > 0) || is_full;
         n_und   = pop && !hd_eof && (q.size() == 1) && !wacc;
         n_start = m_start ? !(pop && hd_eof) : go;
         n_ovf   = (wr_valid && is_full) ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
         if (cfg_we) m_wm = cfg_wm;
         if (pop) void'(q.pop_front());
         if (wacc) q.push_back({wr_eof, wr_data});
         m_start = n_start; m_und = n_und; m_ovf = n_ovf;
      end
   end

   // Cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         bit mv;
         mv = m_start && (q.size() > 0);
         chk("R8 fill_level", fill_level, q.size());
         chk("R3 full", full, q.size() == DEPTH);
         chk("R6 tx_start", tx_start, m_start);
         chk("R7 tx_valid", tx_valid, mv);
         if (mv && tx_valid) begin
            chk("R7 tx_data", tx_data, q[0][DW-1:0]);
            chk("R7 tx_eof", tx_eof, q[0][DW]);
         end
         chk("R3 ovf_flag", ovf_flag, m_ovf);
         chk("R10 underrun", underrun, m_und);
         if (underrun) upulses++;
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic push(bit eof);
      wr_valid = 1'b1; wr_data = seq; wr_eof = eof;
      seq = seq + 8'd1;
      @(negedge clk);
      wr_valid = 1'b0; wr_eof = 1'b0;
   endtask

   task automatic push_n(int n);
      for (int i = 0; i < n; i++) push(1'b0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_wm(logic [1:0] code);
      cfg_we = 1'b1; cfg_wm = code;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      // R1: reset state
      chk("R1 fill_level", fill_level, 0);
      chk("R1 tx_start", tx_start, 0);
      chk("R1 tx_valid", tx_valid, 0);
      chk("R1 ovf_flag", ovf_flag, 0);
      chk("R1 underrun", underrun, 0);

      // R4 / R11: short frame released by its end byte
      push_n(4);
      push(1'b1);
      chk("R11 start not yet", tx_start, 0);
      idle(1);
      chk("R4 early start", tx_start, 1);
      tx_ready = 1'b1;
      idle(8);
      chk("R6 start dropped", tx_start, 0);
      tx_ready = 1'b0;

      // R2: code 00 after reset selects STEP bytes
      push_n(STEP - 1);
      idle(2);
      chk("R2 below 64 (code 00)", tx_start, 0);
      push(1'b0);
      idle(1);
      chk("R2 at 64 (code 00)", tx_start, 1);
      // R9: changing the code after release keeps the request
      set_wm(2'b11);
      idle(2);
      chk("R9 start kept", tx_start, 1);
      // R10: drain dry before the end byte
      upulses = 0;
      tx_ready = 1'b1;
      idle(STEP + 4);
      chk("R10 one pulse", upulses, 1);
      chk("R6 held when empty", tx_start, 1);
      push(1'b1);
      idle(3);
      chk("R6 done after eof", tx_start, 0);
      tx_ready = 1'b0;

      // R2: code 01 also STEP
      set_wm(2'b01);
      push_n(STEP - 1);
      idle(1);
      chk("R2 below 64 (code 01)", tx_start, 0);
      push(1'b0);
      idle(1);
      chk("R2 at 64 (code 01)", tx_start, 1);
      push(1'b1);
      tx_ready = 1'b1;
      idle(STEP + 4);
      tx_ready = 1'b0;

      // R2: code 10 selects 2*STEP
      set_wm(2'b10);
      push_n(2 * STEP - 1);
      idle(2);
      chk("R2 below 128 (code 10)", tx_start, 0);
      push(1'b0);
      idle(1);
      chk("R2 at 128 (code 10)", tx_start, 1);
      push(1'b1);
      // a second complete frame queued behind
      push_n(2);
      push(1'b1);
      tx_ready = 1'b1;
      idle(2 * STEP + 10);
      chk("R6 both frames gone", fill_level, 0);
      tx_ready = 1'b0;

      // R5 / R3: code 11 exceeds depth, so fullness releases
      set_wm(2'b11);
      push_n(DEPTH - 1);
      idle(2);
      chk("R5 not full yet", tx_start, 0);
      push(1'b0);
      chk("R3 full", full, 1);
      idle(1);
      chk("R5 start on full", tx_start, 1);
      push_n(2);
      chk("R3 ovf set", ovf_flag, 1);
      chk("R3 level capped", fill_level, DEPTH);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      chk("R3 ovf cleared", ovf_flag, 0);
      tx_ready = 1'b1;
      idle(3);
      push(1'b1);
      idle(DEPTH + 8);
      chk("R8 drained", fill_level, 0);
      chk("R6 released", tx_start, 0);

      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule